// File: doc/BRIEF.md
# Bank Address Permutation Router

The router sits in front of a multi-bank memory. Each cycle it receives one write address per bank and places them into per-bank address slots. In pass-through mode the mapping is the identity: slot k receives address k. In scatter mode every input carries a run-time bank selector, and address i is steered into the slot that its selector names.

Selectors carry no uniqueness guarantee. In scatter mode a slot can therefore be named by several inputs, or by none. When several inputs name a slot, the input with the highest index wins. A slot that no input names does not form a latch. It keeps the value it showed on the previous cycle, which a register supplies because it captures the whole routed vector on every clock.

The routing path is purely combinational, so the output follows the inputs in the same cycle. A per-slot flag vector reports which slots were written in the current cycle. It makes holes and collisions visible to the surrounding logic.

Top module: `bank_addr_router`

## Requirements
- R1: When `pass_mode` is 1, slot k of `addr_out` equals address k of `addr_in` for every k.
- R2: When `pass_mode` is 0, address i (bits `i*ADDR_W +: ADDR_W`) is placed into the slot whose index equals selector i (bits `i*SEL_W +: SEL_W` of `bank_sel`), with SEL_W = max(1, ceil(log2(NUM_BANKS))).
- R3: In scatter mode, when several selectors name the same slot, that slot takes the address with the highest input index.
- R4: In scatter mode, a slot that no selector names shows the value it had on `addr_out` in the previous clock cycle.
- R5: A selector value of NUM_BANKS or greater names no slot, and its address reaches no output.
- R6: A synchronous active-high `rst` clears the hold register. While reset is applied, and in the first cycle after it, any untargeted slot in scatter mode reads zero.
- R7: Bit k of `slot_hit` is 1 in scatter mode exactly when some in-range selector names slot k. In pass-through mode every bit is 1.
- R8: `addr_out` and `slot_hit` respond to `addr_in`, `bank_sel` and `pass_mode` within the same cycle, with no register stage on the routing path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold register |
| rst | input | 1 | Synchronous active-high reset of the hold register |
| pass_mode | input | 1 | 1 selects identity routing, 0 selects scatter routing |
| addr_in | input | NUM_BANKS*ADDR_W | Packed per-bank input addresses, bank 0 in the low bits |
| bank_sel | input | NUM_BANKS*SEL_W | Packed per-bank destination selectors |
| addr_out | output | NUM_BANKS*ADDR_W | Routed per-slot addresses |
| slot_hit | output | NUM_BANKS | Per-slot written-this-cycle flags |

## Verification
The bench builds the router with five banks and 8-bit addresses, so selectors are three bits wide. Codes 5 to 7 are legal selector values that name no slot, which brings the out-of-range path of R5 within reach next to ordinary holes. With five banks and random selectors, collisions and empty slots occur in most scatter cycles. Long runs in scatter mode also carry held values across many cycles. Directed cases cover the all-on-one-slot collision, the all-out-of-range pattern right after reset, and switches between the two modes.

// File: rtl/bar_pkg.sv
package bar_pkg;
   // Selector width needed to name any of n slots (at least one bit).
   function automatic int sel_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/bar_slot_pick.sv
// One output slot of the scatter crossbar: scans inputs in ascending
// order so the highest-indexed claimant is the last to assign.
module bar_slot_pick #(
   parameter int NUM_BANKS = 5,
   parameter int ADDR_W    = 8,
   parameter int SEL_W     = 3,
   parameter int SLOT      = 0
) (
   input  logic [NUM_BANKS*ADDR_W-1:0] addr_flat,
   input  logic [NUM_BANKS*SEL_W-1:0]  sel_flat,
   input  logic [ADDR_W-1:0]           held_val,
   output logic [ADDR_W-1:0]           slot_val,
   output logic                        slot_hit
);
   localparam logic [SEL_W-1:0] SLOT_CODE = SEL_W'(SLOT);

   always_comb begin
      slot_val = held_val;
      slot_hit = 1'b0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (sel_flat[i*SEL_W +: SEL_W] == SLOT_CODE) begin
            slot_val = addr_flat[i*ADDR_W +: ADDR_W];
            slot_hit = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bar_hold_reg.sv
// Captures the routed vector every cycle to supply the hold value.
module bar_hold_reg #(
   parameter int WIDTH = 40
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end
endmodule

// File: rtl/bank_addr_router.sv
module bank_addr_router #(
   parameter int NUM_BANKS = 5,
   parameter int ADDR_W    = 8,
   parameter int SEL_W     = bar_pkg::sel_width(NUM_BANKS)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        pass_mode,
   input  logic [NUM_BANKS*ADDR_W-1:0] addr_in,
   input  logic [NUM_BANKS*SEL_W-1:0]  bank_sel,
   output logic [NUM_BANKS*ADDR_W-1:0] addr_out,
   output logic [NUM_BANKS-1:0]        slot_hit
);
   localparam int VEC_W = NUM_BANKS * ADDR_W;

   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("bank_addr_router: NUM_BANKS must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("bank_addr_router: ADDR_W must be at least 1");
   end
   if (SEL_W < bar_pkg::sel_width(NUM_BANKS)) begin : g_bad_sel
      $error("bank_addr_router: SEL_W too narrow for NUM_BANKS");
   end

   logic [VEC_W-1:0]     held_q;
   logic [VEC_W-1:0]     scat_vec;
   logic [NUM_BANKS-1:0] scat_hit;

   for (genvar s = 0; s < NUM_BANKS; s++) begin : g_slot
      bar_slot_pick #(
         .NUM_BANKS(NUM_BANKS),
         .ADDR_W   (ADDR_W),
         .SEL_W    (SEL_W),
         .SLOT     (s)
      ) u_pick (
         .addr_flat(addr_in),
         .sel_flat (bank_sel),
         .held_val (held_q[s*ADDR_W +: ADDR_W]),
         .slot_val (scat_vec[s*ADDR_W +: ADDR_W]),
         .slot_hit (scat_hit[s])
      );
   end

   always_comb begin
      if (pass_mode) begin
         addr_out = addr_in;
         slot_hit = '1;
      end else begin
         addr_out = scat_vec;
         slot_hit = scat_hit;
      end
   end

   bar_hold_reg #(.WIDTH(VEC_W)) u_hold (
      .clk(clk),
      .rst(rst),
      .d  (addr_out),
      .q  (held_q)
   );
endmodule

// File: rtl/bar_router_chk.sv
module bar_router_chk #(
   parameter int NUM_BANKS = 5,
   parameter int ADDR_W    = 8,
   parameter int SEL_W     = 3
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        pass_mode,
   input logic [NUM_BANKS*ADDR_W-1:0] addr_in,
   input logic [NUM_BANKS*SEL_W-1:0]  bank_sel,
   input logic [NUM_BANKS*ADDR_W-1:0] addr_out,
   input logic [NUM_BANKS-1:0]        slot_hit
);
   // Set once the previous cycle was outside reset.
   logic live;
   always_ff @(posedge clk) begin
      if (rst) live <= 1'b0;
      else     live <= 1'b1;
   end

   a_r1_identity: assert property (@(posedge clk) disable iff (rst)
      pass_mode |-> addr_out == addr_in);

   a_r7_pass_all_hit: assert property (@(posedge clk) disable iff (rst)
      pass_mode |-> &slot_hit);

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_chk
      logic named;
      always_comb begin
         named = 1'b0;
         for (int i = 0; i < NUM_BANKS; i++)
            if (int'(bank_sel[i*SEL_W +: SEL_W]) == k) named = 1'b1;
      end

      // R4: an empty slot repeats last cycle's output
      a_r4_hold: assert property (@(posedge clk) disable iff (rst)
         (live && !pass_mode && !slot_hit[k]) |->
            addr_out[k*ADDR_W +: ADDR_W] == $past(addr_out[k*ADDR_W +: ADDR_W]));

      // R7 / R5: a flag rises only for a slot some selector names
      a_r7_hit_named: assert property (@(posedge clk) disable iff (rst)
         (!pass_mode && slot_hit[k]) |-> named);

      a_r7_named_hit: assert property (@(posedge clk) disable iff (rst)
         (!pass_mode && named) |-> slot_hit[k]);

      // R6: first cycle after reset, an empty slot reads zero
      a_r6_zero_after_rst: assert property (@(posedge clk) disable iff (rst)
         (!live && !pass_mode && !slot_hit[k]) |->
            addr_out[k*ADDR_W +: ADDR_W] == '0);
   end
endmodule

bind bank_addr_router bar_router_chk #(
   .NUM_BANKS(NUM_BANKS),
   .ADDR_W   (ADDR_W),
   .SEL_W    (SEL_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pass_mode(pass_mode),
   .addr_in  (addr_in),
   .bank_sel (bank_sel),
   .addr_out (addr_out),
   .slot_hit (slot_hit)
);

// File: tb/tb_bank_addr_router.sv
module tb_bank_addr_router;
   localparam int NB = 5;
   localparam int AW = 8;
   localparam int SW = 3;

   logic clk = 1'b0;
   logic rst;
   logic pass_mode;
   logic [NB*AW-1:0] addr_in;
   logic [NB*SW-1:0] bank_sel;
   logic [NB*AW-1:0] addr_out;
   logic [NB-1:0]    slot_hit;

   int total = 0;
   int bad   = 0;
   logic [NB*AW-1:0] held_m;
   logic [NB*AW-1:0] exp_out;
   logic [NB-1:0]    exp_hit;
   bit done = 0;

   always #5 clk = ~clk;

   bank_addr_router #(.NUM_BANKS(NB), .ADDR_W(AW)) dut (
      .clk(clk), .rst(rst), .pass_mode(pass_mode),
      .addr_in(addr_in), .bank_sel(bank_sel),
      .addr_out(addr_out), .slot_hit(slot_hit)
   );

   function automatic void model(
      input logic mode, input logic [NB*AW-1:0] a, input logic [NB*SW-1:0] s,
      input logic [NB*AW-1:0] h, output logic [NB*AW-1:0] o, output logic [NB-1:0] f);
      if (mode) begin
         o = a; f = '1;
      end else begin
         o = h; f = '0;
         for (int i = 0; i < NB; i++) begin
            int t;
            t = int'(s[i*SW +: SW]);
            if (t < NB) begin
               o[t*AW +: AW] = a[i*AW +: AW];
               f[t] = 1'b1;
            end
         end
      end
   endfunction

   task automatic chk(input string tag);
      model(pass_mode, addr_in, bank_sel, held_m, exp_out, exp_hit);
      total++;
      if (addr_out !== exp_out) begin
         bad++;
         $display("FAIL %s addr_out act=%h exp=%h", tag, addr_out, exp_out);
      end
      total++;
      if (slot_hit !== exp_hit) begin
         bad++;
         $display("FAIL R7 slot_hit act=%b exp=%b", slot_hit, exp_hit);
      end
   endtask

   // drive at negedge, check same cycle (R8), then advance model at posedge
   task automatic cyc(input logic r, input logic m,
                      input logic [NB*AW-1:0] a, input logic [NB*SW-1:0] s,
                      input string tag);
      @(negedge clk);
      rst = r; pass_mode = m; addr_in = a; bank_sel = s;
      #3;
      chk(tag);
      @(posedge clk);
      held_m = r ? '0 : exp_out;
   endtask

   function automatic logic [NB*SW-1:0] sels(input int s0, s1, s2, s3, s4);
      return {SW'(s4), SW'(s3), SW'(s2), SW'(s1), SW'(s0)};
   endfunction

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [NB*AW-1:0] av;
      logic [NB*SW-1:0] sv;
      void'($urandom(32'h5eed_1234));
      held_m = '0;
      rst = 1'b1; pass_mode = 1'b0; addr_in = '0; bank_sel = '1;
      @(posedge clk);
      // R6: in reset, out-of-range selectors (R5) leave every slot empty -> zero
      cyc(1'b1, 1'b0, 40'hAA_BB_CC_DD_EE, sels(7, 6, 5, 7, 6), "R6");
      cyc(1'b0, 1'b0, 40'h11_22_33_44_55, sels(7, 7, 7, 7, 7), "R6");
      // R2: permutation, all slots written
      cyc(1'b0, 1'b0, 40'h50_40_30_20_10, sels(4, 3, 2, 1, 0), "R2");
      cyc(1'b0, 1'b0, 40'h0E_0D_0C_0B_0A, sels(2, 0, 4, 1, 3), "R2");
      // R3: all claim slot 1; highest index wins; others hold (R4)
      cyc(1'b0, 1'b0, 40'hF5_F4_F3_F2_F1, sels(1, 1, 1, 1, 1), "R3");
      // R4 / R5: out-of-range only, everything holds
      cyc(1'b0, 1'b0, 40'h99_99_99_99_99, sels(5, 6, 7, 5, 6), "R4");
      cyc(1'b0, 1'b0, 40'h77_66_55_44_33, sels(0, 7, 0, 7, 0), "R5");
      // R1: identity, then back to scatter holding identity result
      cyc(1'b0, 1'b1, 40'hC5_C4_C3_C2_C1, sels(0, 0, 0, 0, 0), "R1");
      cyc(1'b0, 1'b0, 40'h00_00_00_00_00, sels(7, 7, 7, 7, 7), "R4");
      // random mix
      for (int n = 0; n < 3000; n++) begin
         av = {$urandom(), $urandom()};
         sv = 15'($urandom());
         if (n % 50 == 49)
            cyc(1'b1, 1'($urandom_range(0, 1)), av, sv, "R6");
         else if ($urandom_range(0, 3) == 0)
            cyc(1'b0, 1'b1, av, sv, "R1");
         else
            cyc(1'b0, 1'b0, av, sv, "R2");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule